// File: doc/BRIEF.md
# Level Interrupt Cause and Mask Aggregator

This block gathers seven interrupt sources into one level-sensitive request line for a parent interrupt controller. A rising edge on a source input latches a bit in a cause register. A mask register selects which latched causes drive the combined request. Both registers sit on a minimal register port made of a write strobe, an address, write data and a combinational read-data bus.

The cause register is plain read/write. It is not write-0-to-clear: every written bit takes exactly the written value. Writing a 1 raises a software interrupt, and writing a 0 acknowledges one. Software should write back its read value with the serviced bits cleared. A cause that arrives between that read and that write can still be lost. To narrow the window, a hardware event in the same cycle as a cause write always wins for its bit.

Alongside the request line, the block reports the index of the highest-numbered pending unmasked source, with a valid flag. A handler can use it to service sources from the top down. Initialisation writes zero to both registers, which masks and clears everything.

Top module: `irq_cause_agg`

## Requirements
- R1: After synchronous reset (active-low `rst_n`), cause and mask read as 0, `irq_o` is low and `top_valid_o` is low.
- R2: A rising edge on `src_i[i]` sets cause bit i at the next clock edge. A source held high sets its bit only once, so a bit cleared by software while its source stays high remains clear.
- R3: A write to offset 0x50 loads cause bits [6:0] with exactly the written data. A 1 sets a bit, a 0 clears it, and read data bits [31:7] are always 0.
- R4: When a source edge and a cause write hit the same bit in the same cycle, the bit ends up set, even if the write carries a 0.
- R5: A write to offset 0x54 loads the mask from data bits [6:0]. Reading 0x54 returns it. A mask bit of 1 enables its source.
- R6: `irq_o` is high exactly while some cause bit is set whose mask bit is also 1, and it stays high until that condition ends.
- R7: When `top_valid_o` is high, `top_idx_o` is the highest bit number i with cause[i] and mask[i] both set. When no such bit exists, `top_valid_o` is low.
- R8: Writes to any offset other than 0x50 and 0x54 change neither register, and reads from such offsets return 0.
- R9: A cause bit latched while masked stays pending and asserts `irq_o` as soon as its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 7 | Interrupt source levels, edge-detected |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| irq_o | output | 1 | Combined level request to the parent controller |
| top_idx_o | output | 3 | Highest pending unmasked source number |
| top_valid_o | output | 1 | High when any unmasked cause is pending |

## Verification
Two functions can land on the same cause bit in one clock: a source rising edge and a software write to the cause register. The bench provokes this by raising a source in the cycle that writes 0 to the whole cause register. It expects that bit to read back as 1 while every other bit is cleared. It also clears a bit while its source stays high and expects no re-latch. This shows that the level on the source does not fight the write, and only a new edge does.

// File: rtl/irq_agg_pkg.sv
// Package: shared sizing and register offsets for the interrupt cause/mask
// aggregator. Assumes byte offsets fit in 8 bits and the bus is 32 bits.
package irq_agg_pkg;
    localparam int NUM_SRC   = 7;
    localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam logic [ADDR_W-1:0] CAUSE_OFS = 8'h50;
    localparam logic [ADDR_W-1:0] MASK_OFS  = 8'h54;
endpackage

// File: rtl/irq_src_edge.sv
// Module: per-source rising-edge detector.
// Detects a 0->1 transition of each source relative to the previous cycle.
// Assumes sources are already synchronous to clk. The history clears on reset,
// so a source that is high when reset releases produces one edge.
module irq_src_edge #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    // Keep last cycle's source levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_i;
    end

    // One-cycle pulse per bit on a rising edge.
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            assign rise_o[g] = src_i[g] & ~prev_q[g];
        end
    endgenerate
endmodule

// File: rtl/irq_cause_bank.sv
// Module: cause and mask registers with address decode and read mux.
// Cause bits are plain read/write; a hardware edge in the same cycle as a
// cause write overrides the written value for that bit. Assumes the write
// strobe is a single-cycle qualified request.
module irq_cause_bank #(
    parameter int N      = 7,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'h50,
    parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      rise_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    output logic [N-1:0]      cause_o,
    output logic [N-1:0]      mask_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [N-1:0] cause_q, mask_q;
    logic         wr_cause, wr_mask;

    // Address decode of the two writable registers.
    assign wr_cause = wr_i && (addr_i == CAUSE_OFS);
    assign wr_mask  = wr_i && (addr_i == MASK_OFS);

    // Cause register: write loads exactly, edges OR in and win ties.
    always_ff @(posedge clk) begin
        if (!rst_n)        cause_q <= '0;
        else if (wr_cause) cause_q <= wdata_i | rise_i;
        else               cause_q <= cause_q | rise_i;
    end

    // Mask register: plain load.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata_i;
    end

    // Read mux, zero-extended, zero for undecoded offsets.
    always_comb begin
        rdata_o = '0;
        if (addr_i == CAUSE_OFS)     rdata_o[N-1:0] = cause_q;
        else if (addr_i == MASK_OFS) rdata_o[N-1:0] = mask_q;
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;

    // R3: a write with no colliding edge leaves exactly the written value.
    p_write_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cause && rise_i == '0) |=> cause_q == $past(wdata_i));
    // R4: every edge bit is set after the edge, whatever was written.
    p_edge_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((cause_q & $past(rise_i)) == $past(rise_i)));
    // R2: with no write and no edge, the cause register holds.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cause && rise_i == '0) |=> $stable(cause_q));
    // R5: mask write loads the written value.
    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> mask_q == $past(wdata_i));
endmodule

// File: rtl/irq_top_pick.sv
// Module: highest-index picker over the pending vector.
// Pure combinational scan; the last set bit in ascending order wins, which
// gives the highest-numbered pending source.
module irq_top_pick #(
    parameter int N     = 7,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    // Ascending scan so that higher indices overwrite lower ones.
    always_comb begin
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i]) begin
                idx_o   = IDX_W'(i);
                valid_o = 1'b1;
            end
        end
    end

    // R7: the reported index is pending.
    p_pick_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pend_i[idx_o]);
    // R7: nothing above the reported index is pending.
    p_pick_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((pend_i >> idx_o) == N'(1)));
endmodule

// File: rtl/irq_cause_agg.sv
// Module: top of the seven-source level interrupt cause/mask aggregator.
// Sources are edge-detected into a read/write cause register, gated by a
// mask register, and merged into one level output plus a top-index report.
// Assumes all inputs are synchronous to clk.
module irq_cause_agg
    import irq_agg_pkg::*;
#(
    parameter int N      = NUM_SRC,
    parameter int IW     = IDX_W,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_i,
    input  logic          reg_wr_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_o,
    output logic [IW-1:0] top_idx_o,
    output logic          top_valid_o
);
    logic [N-1:0] rise, cause, mask, pend;
    logic         unused_wdata_hi;

    // Upper write-data bits have no storage.
    assign unused_wdata_hi = ^reg_wdata_i[DW-1:N];

    irq_src_edge #(.N(N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise)
    );

    irq_cause_bank #(
        .N(N), .ADDR_W(AW), .DATA_W(DW),
        .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i[N-1:0]),
        .cause_o (cause),
        .mask_o  (mask),
        .rdata_o (reg_rdata_o)
    );

    // Pending = latched and enabled.
    assign pend  = cause & mask;
    // Combined level request.
    assign irq_o = |pend;

    irq_top_pick #(.N(N), .IDX_W(IW)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend),
        .idx_o   (top_idx_o),
        .valid_o (top_valid_o)
    );

    // R6: the level request and the picker agree on "anything pending".
    p_irq_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == top_valid_o);
    // R9: a masked cause bit that becomes enabled raises the request.
    p_unmask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & ~mask) != '0 && reg_wr_i && reg_addr_i == MASK_OFS
         && (reg_wdata_i[N-1:0] & cause) != '0) |=> irq_o);
endmodule

// File: tb/irq_cause_agg_tb.sv
module irq_cause_agg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    localparam int VW = 34;
    localparam logic [7:0] A_CAUSE = 8'h50;
    localparam logic [7:0] A_MASK  = 8'h54;

    // Fields: src[33:27] op[26:25] wd[24:18] exp_cause[17:11] exp_mask[10:4] idx[3:1] valid[0]
    // op: 0 none, 1 write cause, 2 write mask
    localparam logic [VW-1:0] VEC [NV] = '{
        {7'h00, 2'd2, 7'h7F, 7'h00, 7'h7F, 3'd0, 1'b0},  // R5 enable all
        {7'h04, 2'd0, 7'h00, 7'h04, 7'h7F, 3'd2, 1'b1},  // R2 edge sets bit 2
        {7'h04, 2'd1, 7'h00, 7'h00, 7'h7F, 3'd0, 1'b0},  // R2/R3 clear while held
        {7'h04, 2'd0, 7'h00, 7'h00, 7'h7F, 3'd0, 1'b0},  // R2 held: no re-latch
        {7'h00, 2'd1, 7'h41, 7'h41, 7'h7F, 3'd6, 1'b1},  // R3 software set
        {7'h02, 2'd1, 7'h00, 7'h02, 7'h7F, 3'd1, 1'b1},  // R4 edge beats write 0
        {7'h02, 2'd2, 7'h00, 7'h02, 7'h00, 3'd0, 1'b0},  // R5/R6 mask all
        {7'h28, 2'd0, 7'h00, 7'h2A, 7'h00, 3'd0, 1'b0},  // R9 latched while masked
        {7'h28, 2'd2, 7'h08, 7'h2A, 7'h08, 3'd3, 1'b1},  // R9/R7 partial unmask
        {7'h28, 2'd2, 7'h7F, 7'h2A, 7'h7F, 3'd5, 1'b1},  // R7 highest wins
        {7'h00, 2'd1, 7'h0A, 7'h0A, 7'h7F, 3'd3, 1'b1},  // R3/R6 partial ack
        {7'h00, 2'd1, 7'h00, 7'h00, 7'h7F, 3'd0, 1'b0}   // R6 all clear
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  src = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, tvalid;
    logic [2:0]  tidx;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_cause_agg u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_o(irq), .top_idx_o(tidx), .top_valid_o(tvalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        wr = 1'b0;
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "irq", {31'd0, irq}, 32'd0);
        chk("R1", "valid", {31'd0, tvalid}, 32'd0);
        rd(A_CAUSE, d); chk("R1", "cause", d, 32'd0);
        rd(A_MASK, d);  chk("R1", "mask", d, 32'd0);

        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] v;
            v = VEC[k];
            src = v[33:27];
            wdata = {25'd0, v[24:18]};
            wr = (v[26:25] != 2'd0);
            addr = (v[26:25] == 2'd2) ? A_MASK : A_CAUSE;
            @(negedge clk);
            wr = 1'b0;
            chk("R6", $sformatf("vec%0d irq", k), {31'd0, irq}, {31'd0, v[0]});
            chk("R7", $sformatf("vec%0d valid", k), {31'd0, tvalid}, {31'd0, v[0]});
            if (v[0]) chk("R7", $sformatf("vec%0d idx", k), {29'd0, tidx}, {29'd0, v[3:1]});
            rd(A_CAUSE, d); chk("R2", $sformatf("vec%0d cause", k), d, {25'd0, v[17:11]});
            rd(A_MASK, d);  chk("R5", $sformatf("vec%0d mask", k), d, {25'd0, v[10:4]});
        end

        // R3 all-ones write keeps only the seven cause bits
        @(negedge clk);
        wreg(A_CAUSE, 32'hFFFF_FFFF);
        rd(A_CAUSE, d); chk("R3", "cause upper bits", d, 32'h0000_007F);
        chk("R7", "idx all pending", {29'd0, tidx}, 32'd6);

        // R8 undecoded write and read
        @(negedge clk);
        wreg(8'h58, 32'h0);
        rd(A_CAUSE, d); chk("R8", "cause after stray write", d, 32'h7F);
        rd(A_MASK, d);  chk("R8", "mask after stray write", d, 32'h7F);
        rd(8'h58, d);   chk("R8", "stray read", d, 32'd0);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
        rd(A_CAUSE, d); chk("R1", "cause after reset", d, 32'd0);
        rd(A_MASK, d);  chk("R1", "mask after reset", d, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule